// File: doc/BRIEF.md
# Packet Commit Tracker for an IN Endpoint FIFO

This block sits beside the write port of an IN-direction endpoint FIFO and groups the elements written into it into packets for the host-side consumer. It counts the bytes taken in by each write: one per write in byte mode, two per write in word mode. When the running count reaches a programmable length, it closes the packet by itself. An external packet-end strobe closes the current partial packet early at any length, including one byte, one word or nothing at all.

Each commit appears as a one-clock pulse. The pulse carries the committed length and a flag that tells an automatic commit from a manual one. A small counter tracks how many committed packets are waiting for the consumer, and the consumer retires them with a pop strobe. A sticky violation flag records a packet-end strobe sampled on the same edge as the write that completes an automatic packet. That is the one spacing rule the producer must keep. The block discards such a strobe and does not emit an extra empty packet.

Top module: `pkt_commit`

## Requirements
- R1: While rst_ni is low and after its release, commit_o, commit_auto_o, commit_len_o, pkt_cnt_o, pkt_avail_o, pkt_full_o and violation_o are all 0.
- R2: A sampled write (wr_en_i=1) adds 1 to the partial byte count when word_mode_i=0 and 2 when word_mode_i=1.
- R3: When a write brings the partial count to a value ≥ auto_len_i, the packet is committed with commit_auto_o=1 and commit_len_o equal to that count, and the partial count restarts at 0. auto_len_i must be ≥2 in byte mode and ≥3 in word mode.
- R4: A sampled pkt_end_i that does not coincide with an automatic commit commits the partial count as a manual packet (commit_auto_o=0, commit_len_o = count before that edge).
- R5: A manual packet holding exactly one write is committed with length 1 in byte mode and 2 in word mode.
- R6: pkt_end_i sampled while the partial count is 0 commits a zero-length manual packet.
- R7: A write sampled on the same edge as a manual packet-end is not part of the committed packet. It starts the next packet, so the partial count becomes 1 or 2.
- R8: pkt_end_i sampled on the same edge as the write that completes an automatic packet yields only the automatic packet and sets violation_o, which stays 1 until reset.
- R9: pkt_end_i sampled one clock after the edge that completed an automatic packet commits a zero-length manual packet and leaves violation_o unchanged.
- R10: commit_o is high for exactly the one clock after each edge with a commit event, and commit_len_o/commit_auto_o are valid while it is high.
- R11: pkt_cnt_o rises by one per commit and falls by one per pkt_pop_i while nonzero. A pop at zero is ignored, and a commit at MAX_PKTS is not counted. pkt_avail_o = (pkt_cnt_o≠0) and pkt_full_o = (pkt_cnt_o = MAX_PKTS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_mode_i | input | 1 | 1: each write is two bytes; 0: one byte |
| auto_len_i | input | LEN_W | Automatic packet length in bytes |
| wr_en_i | input | 1 | Write strobe |
| pkt_end_i | input | 1 | Manual packet-end strobe |
| pkt_pop_i | input | 1 | Consumer retires one packet |
| commit_o | output | 1 | One-clock commit pulse |
| commit_auto_o | output | 1 | 1: commit was automatic |
| commit_len_o | output | LEN_W | Committed length in bytes |
| pkt_cnt_o | output | CNT_W | Committed packets waiting |
| pkt_avail_o | output | 1 | At least one packet waiting |
| pkt_full_o | output | 1 | Packet counter at MAX_PKTS |
| violation_o | output | 1 | Sticky packet-end spacing violation |

## Verification
The bench builds the block with LEN_W=5 and MAX_PKTS=3, so the counter saturates and empties within a few dozen cycles. Every automatic length from 2 to 12 bytes in byte mode and from 3 to 12 in word mode is swept under a pseudo-random mix of writes, packet-end strobes and pops. Under that mix the partial count crosses odd thresholds in word mode, and packet-end collides with completing writes. Directed sequences cover one-element, empty and correctly spaced short packets.

// File: rtl/pkt_commit_pkg.sv
package pkt_commit_pkg;
  typedef enum logic [1:0] {
    CMT_NONE  = 2'd0,
    CMT_AUTO  = 2'd1,
    CMT_SHORT = 2'd2
  } cmt_kind_e;
endpackage

// File: rtl/pkt_len_acc.sv
module pkt_len_acc
  import pkt_commit_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_mode_i,
  input  logic [LEN_W-1:0] auto_len_i,
  input  logic             wr_en_i,
  input  logic             pkt_end_i,
  output cmt_kind_e        kind_o,
  output logic [LEN_W-1:0] len_o,
  output logic             violation_o
);
  localparam int SUM_W = LEN_W + 1;

  logic [LEN_W-1:0] part_q, part_d;
  logic [SUM_W-1:0] step, next_sum;
  logic             hit;

  assign step     = wr_en_i ? (word_mode_i ? SUM_W'(2) : SUM_W'(1)) : '0;
  assign next_sum = {1'b0, part_q} + step;
  assign hit      = wr_en_i && (next_sum >= {1'b0, auto_len_i});

  always_comb begin
    kind_o = CMT_NONE;
    len_o  = '0;
    part_d = next_sum[LEN_W-1:0];
    if (hit) begin
      kind_o = CMT_AUTO;
      len_o  = next_sum[LEN_W-1:0];
      part_d = '0;
    end else if (pkt_end_i) begin
      kind_o = CMT_SHORT;
      len_o  = part_q;
      part_d = step[LEN_W-1:0];   // same-cycle write opens the next packet
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q      <= '0;
      violation_o <= 1'b0;
    end else begin
      part_q <= part_d;
      if (hit && pkt_end_i) violation_o <= 1'b1;
    end
  end

  assert_viol_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> violation_o);
  assert_byte_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !word_mode_i && !pkt_end_i && kind_o == CMT_NONE)
      |=> part_q == $past(part_q) + LEN_W'(1));
  assert_collide_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && kind_o == CMT_AUTO) |=> violation_o);
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o != CMT_NONE) |=> part_q <= LEN_W'(2));
endmodule

// File: rtl/pkt_cnt_track.sv
module pkt_cnt_track #(
  parameter int MAX_PKTS = 4,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             avail_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PKTS);

  logic [CNT_W-1:0] cnt_q, after_pop;

  assign after_pop = (pop_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (push_i && after_pop != MAX_C) cnt_q <= after_pop + 1'b1;
    else                                cnt_q <= after_pop;
  end

  assign cnt_o   = cnt_q;
  assign avail_o = cnt_q != '0;
  assign full_o  = cnt_q == MAX_C;

  assert_cnt_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
  assert_push_counts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt_q != MAX_C) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_empty_pop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/pkt_commit.sv
module pkt_commit
  import pkt_commit_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int MAX_PKTS = 4,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_mode_i,
  input  logic [LEN_W-1:0] auto_len_i,
  input  logic             wr_en_i,
  input  logic             pkt_end_i,
  input  logic             pkt_pop_i,
  output logic             commit_o,
  output logic             commit_auto_o,
  output logic [LEN_W-1:0] commit_len_o,
  output logic [CNT_W-1:0] pkt_cnt_o,
  output logic             pkt_avail_o,
  output logic             pkt_full_o,
  output logic             violation_o
);
  cmt_kind_e        kind;
  logic [LEN_W-1:0] len;
  logic             any_cmt;

  pkt_len_acc #(.LEN_W(LEN_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_mode_i (word_mode_i),
    .auto_len_i  (auto_len_i),
    .wr_en_i     (wr_en_i),
    .pkt_end_i   (pkt_end_i),
    .kind_o      (kind),
    .len_o       (len),
    .violation_o (violation_o)
  );

  assign any_cmt = kind != CMT_NONE;

  pkt_cnt_track #(.MAX_PKTS(MAX_PKTS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (any_cmt),
    .pop_i   (pkt_pop_i),
    .cnt_o   (pkt_cnt_o),
    .avail_o (pkt_avail_o),
    .full_o  (pkt_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o      <= 1'b0;
      commit_auto_o <= 1'b0;
      commit_len_o  <= '0;
    end else begin
      commit_o      <= any_cmt;
      commit_auto_o <= kind == CMT_AUTO;
      commit_len_o  <= any_cmt ? len : '0;
    end
  end

  assert_end_commits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i |=> commit_o);
  assert_quiet_no_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_end_i && !wr_en_i) |=> !commit_o);
  assert_auto_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && commit_auto_o) |-> commit_len_o >= LEN_W'(1));
endmodule

// File: tb/sim_pkt_commit.sv
module sim_pkt_commit;
  localparam int LEN_W = 5;
  localparam int MAXP  = 3;
  localparam int CW    = $clog2(MAXP + 1);

  logic clk = 0, rst_ni = 0;
  logic wm = 0, we = 0, pe = 0, pop = 0;
  logic [LEN_W-1:0] alen = 5'd4;
  logic c_o, ca_o, av_o, fu_o, vi_o;
  logic [LEN_W-1:0] cl_o;
  logic [CW-1:0] cnt_o;

  always #10 clk = ~clk;

  pkt_commit #(.LEN_W(LEN_W), .MAX_PKTS(MAXP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .word_mode_i(wm), .auto_len_i(alen),
    .wr_en_i(we), .pkt_end_i(pe), .pkt_pop_i(pop),
    .commit_o(c_o), .commit_auto_o(ca_o), .commit_len_o(cl_o),
    .pkt_cnt_o(cnt_o), .pkt_avail_o(av_o), .pkt_full_o(fu_o), .violation_o(vi_o));

  int n_chk = 0, n_bad = 0;
  int m_part, m_cnt, m_viol;
  int e_c, e_a, e_l;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; we = 0; pe = 0; pop = 0;
    repeat (2) @(posedge clk);
    #2;
    chk({c_o, ca_o, cl_o, cnt_o, av_o, fu_o, vi_o} == '0, "R1 in reset", int'(cnt_o), 0);
    rst_ni = 1;
    @(posedge clk); #2;
    chk({c_o, cl_o, cnt_o, vi_o} == '0, "R1 after release", int'(cl_o), 0);
    m_part = 0; m_cnt = 0; m_viol = 0;
  endtask

  // one clock with given inputs, then compare against the arithmetic model
  task automatic step(bit w, bit p, bit q, string tag);
    int inc, nxt, c;
    we = w; pe = p; pop = q;
    inc = w ? (wm ? 2 : 1) : 0;
    nxt = m_part + inc;
    if (w && nxt >= int'(alen)) begin
      e_c = 1; e_a = 1; e_l = nxt; m_part = 0;
      if (p) m_viol = 1;
    end else if (p) begin
      e_c = 1; e_a = 0; e_l = m_part; m_part = inc;
    end else begin
      e_c = 0; e_a = 0; e_l = 0; m_part = nxt;
    end
    c = m_cnt;
    if (q && c > 0) c--;
    if (e_c == 1 && c < MAXP) c++;
    m_cnt = c;
    @(posedge clk); #2;
    we = 0; pe = 0; pop = 0;
    chk(int'(c_o) == e_c, {tag, " R10 pulse"}, int'(c_o), e_c);
    if (e_c == 1) begin
      chk(int'(cl_o) == e_l && int'(ca_o) == e_a, {tag, " R3/R4 len"},
          int'(cl_o) * 2 + int'(ca_o), e_l * 2 + e_a);
    end
    chk(int'(cnt_o) == m_cnt && av_o == (m_cnt != 0) && fu_o == (m_cnt == MAXP),
        "R11 count", int'(cnt_o), m_cnt);
    chk(int'(vi_o) == m_viol, "R8 viol", int'(vi_o), m_viol);
  endtask

  initial begin
    fork
      begin
        // directed: byte mode, length 4
        wm = 0; alen = 5'd4; do_reset();
        step(1, 0, 0, "R2"); step(1, 0, 0, "R2"); step(1, 0, 0, "R2");
        step(1, 0, 0, "R3 auto4");
        chk(cl_o == 5'd4 && ca_o, "R3 auto len 4", int'(cl_o), 4);
        step(1, 0, 0, "R5"); step(0, 1, 0, "R5 one byte");
        chk(cl_o == 5'd1 && !ca_o, "R5 one byte", int'(cl_o), 1);
        step(0, 1, 0, "R6 zero");
        chk(c_o && cl_o == 5'd0, "R6 zero len", int'(cl_o), 0);
        step(1, 0, 0, "R7"); step(1, 1, 0, "R7 overlap");
        chk(cl_o == 5'd1, "R7 committed excl. write", int'(cl_o), 1);
        step(0, 1, 0, "R7 carry");
        chk(cl_o == 5'd1, "R7 carried write", int'(cl_o), 1);
        step(1, 0, 1, "R11"); step(1, 0, 1, "R11"); step(1, 0, 1, "R11");
        step(1, 0, 0, "R9 auto"); step(0, 1, 0, "R9 spaced");
        chk(c_o && cl_o == 5'd0 && !vi_o, "R9 spaced zero", int'(vi_o), 0);
        step(1, 0, 0, "R8"); step(1, 0, 0, "R8"); step(1, 0, 0, "R8");
        step(1, 1, 0, "R8 collide");
        chk(vi_o && ca_o && cl_o == 5'd4, "R8 collide", int'(vi_o), 1);
        step(0, 0, 0, "R8 no extra");
        chk(!c_o && vi_o, "R8 no extra packet", int'(c_o), 0);
        // directed: word mode, length 5 (odd threshold)
        wm = 1; alen = 5'd5; do_reset();
        step(1, 0, 0, "R2w"); step(1, 0, 0, "R2w"); step(1, 0, 0, "R3w cross");
        chk(cl_o == 5'd6 && ca_o, "R3 word crossing", int'(cl_o), 6);
        step(1, 0, 0, "R5w"); step(0, 1, 0, "R5 one word");
        chk(cl_o == 5'd2 && !ca_o, "R5 one word", int'(cl_o), 2);
        // sweep
        for (int mode = 0; mode < 2; mode++) begin
          for (int l = (mode == 1 ? 3 : 2); l <= 12; l++) begin
            wm = mode[0]; alen = LEN_W'(l); do_reset();
            for (int k = 0; k < 120; k++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              step(lfsr[0] | lfsr[1], lfsr[4:2] == 3'b0, lfsr[5] & lfsr[6], "sweep");
            end
          end
        end
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule